// File: doc/BRIEF.md
# Split-Register Real-Time Counter

This block keeps a 47-bit count of low-power timebase ticks and makes it visible to software as two 32-bit registers: one holding the top 15 bits of the count and one holding the bottom 32 bits. Each pulse on the tick-enable input advances the count by one. At 32768 pulses per second this gives one second per 2^15 counts.

Software can set either half of the count without touching the other half. The new value is built from the count as it stood at the clock edge of the write. A tick that falls on that same edge is discarded, so the half that was not written cannot shift during the update. Beside the counter sits a 32-bit control register. A write that leaves both bit 6 and bit 5 of that register set produces a single-cycle power-off request.

There are two resets. The power-on reset clears everything. The warm reset clears only the control register and the power-off request, so the count behaves like a battery-backed clock across a system reset. The register bus is plain: address, write strobe and write data are sampled on the rising clock edge, and read data is a combinational function of the address and the current state.

Top module: `rtc_split_counter`

## Requirements
- R1: While the power-on reset is active, the control register, both count registers and the power-off request are all zero.
- R2: Each clock edge with the tick input high, and no count-register write, adds one to the 47-bit count. The addition carries from bit 31 into bit 32, and the count wraps from 2^47-1 to 0. With the tick input low, the count holds.
- R3: A read at offset 0x54 returns count bits 31:0. A read at offset 0x50 returns count bits 46:32 in data bits 14:0, with data bits 31:15 reading as zero.
- R4: A write at offset 0x50 sets count bits 46:32 from write-data bits 14:0 and leaves count bits 31:0 unchanged. Write-data bits 31:15 have no effect.
- R5: A write at offset 0x54 sets count bits 31:0 from the write data and leaves count bits 46:32 unchanged.
- R6: When a count-register write and a tick fall on the same edge, the written half takes the written value and the other half keeps its value from before that edge. The tick is lost, and there is no increment or carry.
- R7: Offset 0x38 is a 32-bit control register that reads back whatever was last written to it.
- R8: The power-off request is high for exactly the one cycle after an edge that writes offset 0x38 with data bits 6 and 5 both set. At all other times it is low.
- R9: The warm reset clears the control register and leaves the count unchanged.
- R10: Reads at any offset other than 0x38, 0x50 and 0x54 return zero. Writes to those offsets change neither the count nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| warm_rst_n | input | 1 | Warm reset, active low, asynchronous; clears control only |
| tick_en | input | 1 | One-cycle count enable at the timebase rate |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwr_off_req | output | 1 | One-cycle power-off request pulse |

## Verification
Assertions check on every cycle that the count steps by exactly one on a tick, holds when idle, and takes each partial write with the other half untouched. They also check that a power-off pulse always follows a qualifying control write and that the warm reset holds the control register at zero. Only the bench's scenarios can show what is visible through the register bus. That includes zero padding of the upper register, zero reads across the whole unmapped address space, the dropped tick when a tick collides with a write, carry and wrap across the register split, and survival of the count through a warm reset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_HI   = 2'd2,
    SEL_LO   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rtc_reg_decode.sv
module rtc_reg_decode
  import rtc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int OFF_CTL = 'h38,
  parameter int OFF_HI  = 'h50,
  parameter int OFF_LO  = 'h54
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFF_CTL);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(OFF_HI);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(OFF_LO);

  // Full-width compare: any other offset is unmapped.
  always_comb begin
    if (addr == A_CTL)     sel = SEL_CTRL;
    else if (addr == A_HI) sel = SEL_HI;
    else if (addr == A_LO) sel = SEL_LO;
    else                   sel = SEL_NONE;
  end
endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int CNT_W  = 47,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick_en,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // cnt_q is the single snapshot both halves are taken from; a load
  // overrides the tick on the same edge.
  always_comb begin
    cnt_d = cnt_q;
    if (load_hi)      cnt_d = {wdata[HI_W-1:0], cnt_q[DATA_W-1:0]};
    else if (load_lo) cnt_d = {cnt_q[CNT_W-1:DATA_W], wdata};
    else if (tick_en) cnt_d = cnt_q + 1'b1;
  end

  // Only power-on reset touches the count.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  a_r2_tick_step: assert property (@(posedge clk) disable iff (!por_n)
    (tick_en && !load_hi && !load_lo) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!tick_en && !load_hi && !load_lo) |=> $stable(cnt_q));

  a_r4_hi_load: assert property (@(posedge clk) disable iff (!por_n)
    load_hi |=> (cnt_q[DATA_W-1:0] == $past(cnt_q[DATA_W-1:0]) &&
                 cnt_q[CNT_W-1:DATA_W] == $past(wdata[HI_W-1:0])));

  a_r5_lo_load: assert property (@(posedge clk) disable iff (!por_n)
    load_lo |=> (cnt_q[CNT_W-1:DATA_W] == $past(cnt_q[CNT_W-1:DATA_W]) &&
                 cnt_q[DATA_W-1:0] == $past(wdata)));
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int DATA_W = 32,
  parameter int BIT_A  = 6,
  parameter int BIT_B  = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl,
  output logic              pwr_off_req
);
  logic rst_n;
  assign rst_n = por_n & warm_rst_n;

  logic [DATA_W-1:0] ctrl_q;
  logic              off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      off_q  <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= wdata;
      off_q <= wr_en & wdata[BIT_A] & wdata[BIT_B];
    end
  end

  assign ctrl        = ctrl_q;
  assign pwr_off_req = off_q;

  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> ($past(wr_en) && $past(wdata[BIT_A]) && $past(wdata[BIT_B])));

  a_r8_pulse_bits: assert property (@(posedge clk) disable iff (!rst_n)
    off_q |-> (ctrl_q[BIT_A] && ctrl_q[BIT_B]));

  a_r9_ctrl_cleared: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n |-> (ctrl_q == '0 && !off_q));
endmodule

// File: rtl/rtc_split_counter.sv
module rtc_split_counter
  import rtc_pkg::*;
#(
  parameter int CNT_W   = 47,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int OFF_CTL = 'h38,
  parameter int OFF_HI  = 'h50,
  parameter int OFF_LO  = 'h54
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwr_off_req
);
  localparam int HI_W = CNT_W - DATA_W;

  reg_sel_e          sel;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] ctrl;
  logic              wr_ctrl, wr_hi, wr_lo;

  rtc_reg_decode #(
    .ADDR_W(ADDR_W), .OFF_CTL(OFF_CTL), .OFF_HI(OFF_HI), .OFF_LO(OFF_LO)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  assign wr_ctrl = bus_we && (sel == SEL_CTRL);
  assign wr_hi   = bus_we && (sel == SEL_HI);
  assign wr_lo   = bus_we && (sel == SEL_LO);

  rtc_tick_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk    (clk),
    .por_n  (por_n),
    .tick_en(tick_en),
    .load_hi(wr_hi),
    .load_lo(wr_lo),
    .wdata  (bus_wdata),
    .count  (count)
  );

  rtc_ctrl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .por_n      (por_n),
    .warm_rst_n (warm_rst_n),
    .wr_en      (wr_ctrl),
    .wdata      (bus_wdata),
    .ctrl       (ctrl),
    .pwr_off_req(pwr_off_req)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: bus_rdata = ctrl;
      SEL_HI:   bus_rdata = {{(DATA_W-HI_W){1'b0}}, count[CNT_W-1:DATA_W]};
      SEL_LO:   bus_rdata = count[DATA_W-1:0];
      default:  bus_rdata = '0;
    endcase
  end

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!por_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/rtc_split_counter_test.sv
module rtc_split_counter_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic        tick_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwr_off_req;

  int total = 0;
  int bad = 0;
  logic [46:0] exp_cnt = '0;
  logic [31:0] exp_ctl = '0;
  logic [31:0] rv;

  localparam logic [7:0] A_CTL = 8'h38, A_HI = 8'h50, A_LO = 8'h54;

  always #5 clk = ~clk;

  rtc_split_counter uut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .tick_en(tick_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwr_off_req(pwr_off_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
      exp_cnt = exp_cnt + 47'(n);
    end
  endtask

  task automatic check_cnt(input string req);
    rd(A_HI, rv); check(req, rv, {17'b0, exp_cnt[46:32]});
    rd(A_LO, rv); check(req, rv, exp_cnt[31:0]);
  endtask

  initial begin
    #(2000000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 power-on state
    repeat (3) @(negedge clk);
    check("R1 ctrl", uut.bus_rdata & 32'h0, 32'h0);
    bus_addr = A_CTL; #1; check("R1 ctrl", bus_rdata, 32'h0);
    bus_addr = A_HI;  #1; check("R1 hi", bus_rdata, 32'h0);
    bus_addr = A_LO;  #1; check("R1 lo", bus_rdata, 32'h0);
    check("R1 pwr", {31'b0, pwr_off_req}, 32'h0);
    @(negedge clk); por_n = 1'b1;

    // R2 ticking and hold
    ticks(5); check_cnt("R2 count");
    repeat (4) @(negedge clk); check_cnt("R2 hold");

    // R5 lower-half sweep with ticks
    for (int i = 0; i < 40; i++) begin
      logic [31:0] v;
      v = 32'h0F0F1235 * i ^ 32'hA5A50000;
      wr(A_LO, v); exp_cnt[31:0] = v;
      check_cnt("R5 lo write");
      ticks(i % 4); check_cnt("R2 after lo write");
    end

    // R4 upper-half sweep, upper write-data bits ignored, R3 padding
    for (int i = 0; i < 32; i++) begin
      logic [31:0] v;
      v = ((i * 32'h0000_0421) & 32'h7FFF) | (32'hFFFF8000 * (i & 1));
      wr(A_HI, v); exp_cnt[46:32] = v[14:0];
      check_cnt("R4 hi write");
      rd(A_HI, rv); check("R3 hi pad", rv & 32'hFFFF8000, 32'h0);
    end

    // R2 carry across halves and wrap
    wr(A_HI, 32'h12); wr(A_LO, 32'hFFFFFFFF);
    exp_cnt = {15'h12, 32'hFFFFFFFF};
    ticks(1); check_cnt("R2 carry");
    wr(A_HI, 32'h7FFF); wr(A_LO, 32'hFFFFFFFF);
    exp_cnt = {15'h7FFF, 32'hFFFFFFFF};
    ticks(1); check_cnt("R2 wrap");

    // R6 tick on the same edge as a write
    wr(A_HI, 32'h0033); wr(A_LO, 32'hFFFFFFFE);
    @(negedge clk);
    tick_en = 1'b1; bus_addr = A_LO; bus_wdata = 32'hFFFFFFFF; bus_we = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
    exp_cnt = {15'h0033, 32'hFFFFFFFF};
    check_cnt("R6 lo vs tick");
    @(negedge clk);
    tick_en = 1'b1; bus_addr = A_HI; bus_wdata = 32'h0044; bus_we = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0;
    exp_cnt = {15'h0044, 32'hFFFFFFFF};
    check_cnt("R6 hi vs tick");

    // R7 control readback, R8 power-off pulse over bit 6/5 combinations
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'h1234_5600 ^ (32'h0 | ((i & 3) << 5)) ^ (i << 12);
      wr(A_CTL, v); exp_ctl = v;
      check("R8 pulse", {31'b0, pwr_off_req}, {31'b0, v[6] & v[5]});
      @(negedge clk);
      check("R8 one cycle", {31'b0, pwr_off_req}, 32'h0);
      rd(A_CTL, rv); check("R7 ctrl", rv, exp_ctl);
    end
    wr(A_CTL, 32'hFFFF_FFFF); exp_ctl = 32'hFFFF_FFFF;
    check("R8 all ones", {31'b0, pwr_off_req}, 32'h1);
    rd(A_CTL, rv); check("R7 ctrl ones", rv, exp_ctl);

    // R10 unmapped offsets
    wr(8'h40, 32'hDEADBEEF); wr(8'h58, 32'h0BADF00D); wr(8'h3C, 32'h1);
    rd(A_CTL, rv); check("R10 ctrl kept", rv, exp_ctl);
    check_cnt("R10 count kept");
    for (int a = 0; a < 256; a++) begin
      if (a != 'h38 && a != 'h50 && a != 'h54) begin
        rd(8'(a), rv); check("R10 unmapped read", rv, 32'h0);
      end
    end

    // R9 warm reset
    wr(A_CTL, 32'h5A5A_0060); exp_ctl = 32'h5A5A_0060;
    @(negedge clk); warm_rst_n = 1'b0;
    @(negedge clk); warm_rst_n = 1'b1;
    rd(A_CTL, rv); check("R9 ctrl cleared", rv, 32'h0);
    check_cnt("R9 count kept");
    ticks(3); check_cnt("R9 ticks after warm");

    // R1 power-on reset again
    wr(A_CTL, 32'h77);
    @(negedge clk); por_n = 1'b0;
    bus_addr = A_CTL; #1; check("R1 ctrl", bus_rdata, 32'h0);
    bus_addr = A_HI;  #1; check("R1 hi", bus_rdata, 32'h0);
    bus_addr = A_LO;  #1; check("R1 lo", bus_rdata, 32'h0);
    @(negedge clk); por_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule